// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Selector

This block picks, for every CPU of a multi-core cluster, the interrupt that CPU should see next. A neighbouring register block holds the interrupt state and presents it as wide vectors. Each CPU has its own enable and pending bit for every interrupt ID. IDs below 32 take their 8-bit priority from a bank private to the CPU, and higher IDs take it from one table shared by all CPUs. For each CPU the selector finds the enabled and pending interrupt with the numerically lowest priority and publishes its ID. It drives that CPU's request line when the winner may preempt the CPU's current work.

The result passes two gates. The CPU's priority mask decides whether the winner is published at all. The CPU's running priority decides whether the request line is raised. The running priority is 9 bits wide, so the idle value 0x100 lies below every real 8-bit priority. A global distributor enable and a per-CPU interface enable force the CPU's output to "nothing pending" when either is off. Outputs are registered: any change on the inputs shows on the outputs one clock later. The ID count `NIRQ` must be a multiple of 32 from 32 to 1020.

Top module: `gic_prio_select`

## Requirements
- R1: While reset is held, every CPU's published ID is 1023 (no interrupt) and every request line is low.
- R2: When `dist_en_i` is 0 or a CPU's bit of `cpu_en_i` is 0, that CPU publishes 1023 and its request line is low.
- R3: Interrupt `id` is a candidate for CPU `c` only if both `enable_i[c*NIRQ+id]` and `pending_i[c*NIRQ+id]` are 1.
- R4: Among the candidates, the lowest priority value wins. On equal priorities the lowest ID wins.
- R5: For `id < 32` the priority is `prio_bank_i[(c*32+id)*8 +: 8]`, private to CPU `c`. For `id >= 32` it is `prio_shared_i[(id-32)*8 +: 8]`, the same for every CPU.
- R6: The winner is published only if its priority is less than or equal to the CPU's mask `pmask_i[c*8 +: 8]`. Otherwise the CPU publishes 1023. With no candidate the CPU publishes 1023.
- R7: The request line `irq_o[c]` is 1 only when a winner is published and its priority is strictly less than the 9-bit running priority `run_prio_i[c*9 +: 9]`. A running priority of 0x100 means idle.
- R8: The outputs at a clock edge reflect the inputs sampled at that edge, so an input change reaches the outputs one cycle later.
- R9: The published ID `hp_id_o[c*10 +: 10]` is always either 1023 or less than `NIRQ`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dist_en_i | input | 1 | Global distributor enable |
| cpu_en_i | input | NCPU | Per-CPU interface enable |
| enable_i | input | NCPU*NIRQ | Per-CPU enable bits, CPU-major |
| pending_i | input | NCPU*NIRQ | Per-CPU pending bits, CPU-major |
| prio_bank_i | input | NCPU*32*8 | Banked priorities of IDs 0..31, CPU-major |
| prio_shared_i | input | (NIRQ-32)*8 | Shared priorities of IDs 32 and up |
| pmask_i | input | NCPU*8 | Per-CPU priority mask |
| run_prio_i | input | NCPU*9 | Per-CPU running priority, 0x100 = idle |
| hp_id_o | output | NCPU*10 | Per-CPU highest-pending ID, 1023 = none |
| irq_o | output | NCPU | Per-CPU interrupt request line |

## Verification
The checker assumes the inputs change only between clock edges. It also assumes `NIRQ` is larger than 32, so the shared table has at least one real entry. It relies on registered copies of the inputs taken at the same edge as the outputs, and judges each published ID against the enable, pending, priority, mask and running-priority values of the previous cycle. The bench changes inputs only on the falling edge. Its directed phases cover mask and running-priority equality, banked versus shared priorities and ties. A random phase draws sparse pending sets and running priorities that include the idle value 0x100.

// File: rtl/gic_sel_pkg.sv
package gic_sel_pkg;
    localparam int ID_W    = 10;
    localparam int PRIO_W  = 8;
    localparam int RUN_W   = PRIO_W + 1;
    localparam int BANKED  = 32;
    localparam logic [ID_W-1:0]  NO_IRQ   = 10'd1023;
    localparam logic [RUN_W-1:0] PRIO_NONE = 9'h100;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            req;
    } slot_t;
endpackage

// File: rtl/gic_prio_map.sv
module gic_prio_map
    import gic_sel_pkg::*;
#(
    parameter int NIRQ = 64,
    localparam int SH_N = (NIRQ > BANKED) ? (NIRQ - BANKED) : 1
) (
    input  logic [BANKED*PRIO_W-1:0] bank_i,
    input  logic [SH_N*PRIO_W-1:0]   shared_i,
    output logic [NIRQ*PRIO_W-1:0]   prio_o
);
    for (genvar i = 0; i < NIRQ; i++) begin : g_id
        if (i < BANKED) begin : g_bank
            assign prio_o[i*PRIO_W +: PRIO_W] = bank_i[i*PRIO_W +: PRIO_W];
        end else begin : g_shared
            assign prio_o[i*PRIO_W +: PRIO_W] = shared_i[(i-BANKED)*PRIO_W +: PRIO_W];
        end
    end
endmodule

// File: rtl/gic_best_scan.sv
module gic_best_scan
    import gic_sel_pkg::*;
#(
    parameter int NIRQ = 64,
    localparam int LEAVES = 1 << $clog2(NIRQ)
) (
    input  logic [NIRQ-1:0]        cand_i,
    input  logic [NIRQ*PRIO_W-1:0] prio_i,
    output logic [ID_W-1:0]        best_id_o,
    output logic [RUN_W-1:0]       best_prio_o
);
    logic [RUN_W-1:0] node_prio [1:2*LEAVES-1];
    logic [ID_W-1:0]  node_id   [1:2*LEAVES-1];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NIRQ) begin : g_real
            assign node_prio[LEAVES+i] = cand_i[i] ? {1'b0, prio_i[i*PRIO_W +: PRIO_W]} : PRIO_NONE;
            assign node_id[LEAVES+i]   = ID_W'(i);
        end else begin : g_pad
            assign node_prio[LEAVES+i] = PRIO_NONE;
            assign node_id[LEAVES+i]   = NO_IRQ;
        end
    end

    // Left subtree holds lower IDs; it keeps the node unless the right is strictly better.
    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        logic take_right;
        assign take_right   = node_prio[2*n+1] < node_prio[2*n];
        assign node_prio[n] = take_right ? node_prio[2*n+1] : node_prio[2*n];
        assign node_id[n]   = take_right ? node_id[2*n+1]   : node_id[2*n];
    end

    assign best_id_o   = node_id[1];
    assign best_prio_o = node_prio[1];
endmodule

// File: rtl/gic_prio_select.sv
module gic_prio_select
    import gic_sel_pkg::*;
#(
    parameter int NIRQ = 64,
    parameter int NCPU = 2,
    localparam int SH_N = (NIRQ > BANKED) ? (NIRQ - BANKED) : 1
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         dist_en_i,
    input  logic [NCPU-1:0]              cpu_en_i,
    input  logic [NCPU*NIRQ-1:0]         enable_i,
    input  logic [NCPU*NIRQ-1:0]         pending_i,
    input  logic [NCPU*BANKED*PRIO_W-1:0] prio_bank_i,
    input  logic [SH_N*PRIO_W-1:0]       prio_shared_i,
    input  logic [NCPU*PRIO_W-1:0]       pmask_i,
    input  logic [NCPU*RUN_W-1:0]        run_prio_i,
    output logic [NCPU*ID_W-1:0]         hp_id_o,
    output logic [NCPU-1:0]              irq_o
);
    logic [ID_W-1:0]  best_id   [NCPU];
    logic [RUN_W-1:0] best_prio [NCPU];

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NIRQ*PRIO_W-1:0] prio_c;
        logic [NIRQ-1:0]        cand_c;

        assign cand_c = enable_i[c*NIRQ +: NIRQ] & pending_i[c*NIRQ +: NIRQ];

        gic_prio_map #(.NIRQ(NIRQ)) u_map (
            .bank_i   (prio_bank_i[c*BANKED*PRIO_W +: BANKED*PRIO_W]),
            .shared_i (prio_shared_i),
            .prio_o   (prio_c)
        );

        gic_best_scan #(.NIRQ(NIRQ)) u_scan (
            .cand_i      (cand_c),
            .prio_i      (prio_c),
            .best_id_o   (best_id[c]),
            .best_prio_o (best_prio[c])
        );
    end

    slot_t [NCPU-1:0] st_d, st_q;

    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            st_d[c].id  = NO_IRQ;
            st_d[c].req = 1'b0;
            if (dist_en_i && cpu_en_i[c]) begin
                if (best_prio[c] <= {1'b0, pmask_i[c*PRIO_W +: PRIO_W]}) begin
                    st_d[c].id  = best_id[c];
                    st_d[c].req = best_prio[c] < run_prio_i[c*RUN_W +: RUN_W];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int c = 0; c < NCPU; c++) begin
                st_q[c].id  <= NO_IRQ;
                st_q[c].req <= 1'b0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_out
        assign hp_id_o[c*ID_W +: ID_W] = st_q[c].id;
        assign irq_o[c]                = st_q[c].req;
    end
endmodule

// File: rtl/gic_sel_chk.sv
module gic_sel_chk
    import gic_sel_pkg::*;
#(
    parameter int NIRQ = 64,
    parameter int NCPU = 2,
    localparam int SH_N = (NIRQ > BANKED) ? (NIRQ - BANKED) : 1
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic                          dist_en_i,
    input logic [NCPU-1:0]               cpu_en_i,
    input logic [NCPU*NIRQ-1:0]          enable_i,
    input logic [NCPU*NIRQ-1:0]          pending_i,
    input logic [NCPU*BANKED*PRIO_W-1:0] prio_bank_i,
    input logic [SH_N*PRIO_W-1:0]        prio_shared_i,
    input logic [NCPU*PRIO_W-1:0]        pmask_i,
    input logic [NCPU*RUN_W-1:0]         run_prio_i,
    input logic [NCPU*ID_W-1:0]          hp_id_o,
    input logic [NCPU-1:0]               irq_o
);
    logic [NCPU*NIRQ-1:0]          en_q, pend_q;
    logic [NCPU*BANKED*PRIO_W-1:0] bank_q;
    logic [SH_N*PRIO_W-1:0]        shared_q;
    logic [NCPU*PRIO_W-1:0]        mask_q;
    logic [NCPU*RUN_W-1:0]         run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q <= '0; pend_q <= '0; bank_q <= '0;
            shared_q <= '0; mask_q <= '0; run_q <= '0;
        end else begin
            en_q <= enable_i; pend_q <= pending_i; bank_q <= prio_bank_i;
            shared_q <= prio_shared_i; mask_q <= pmask_i; run_q <= run_prio_i;
        end
    end

    function automatic logic [PRIO_W-1:0] prio_of(int c, int id);
        if (id < BANKED) return bank_q[(c*BANKED+id)*PRIO_W +: PRIO_W];
        return shared_q[(id-BANKED)*PRIO_W +: PRIO_W];
    endfunction

    for (genvar c = 0; c < NCPU; c++) begin : g_c
        logic [ID_W-1:0]   hp;
        logic [PRIO_W-1:0] wp;
        logic              win_cand, better;

        assign hp = hp_id_o[c*ID_W +: ID_W];

        always_comb begin
            wp = '0;
            win_cand = 1'b0;
            better = 1'b0;
            if (int'(hp) < NIRQ) begin
                wp = prio_of(c, int'(hp));
                win_cand = en_q[c*NIRQ+int'(hp)] && pend_q[c*NIRQ+int'(hp)];
                for (int i = 0; i < NIRQ; i++) begin
                    if (en_q[c*NIRQ+i] && pend_q[c*NIRQ+i] &&
                        (prio_of(c, i) < wp || (prio_of(c, i) == wp && i < int'(hp))))
                        better = 1'b1;
                end
            end
        end

        p_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!dist_en_i || !cpu_en_i[c]) |=> (hp_id_o[c*ID_W +: ID_W] == NO_IRQ && !irq_o[c]));

        p_cand_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hp != NO_IRQ) |-> win_cand);

        p_best_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hp != NO_IRQ) |-> !better);

        p_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hp != NO_IRQ) |-> (wp <= mask_q[c*PRIO_W +: PRIO_W]));

        p_preempt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[c] |-> (hp != NO_IRQ && {1'b0, wp} < run_q[c*RUN_W +: RUN_W]));

        p_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hp == NO_IRQ) || (int'(hp) < NIRQ));
    end
endmodule

bind gic_prio_select gic_sel_chk #(.NIRQ(NIRQ), .NCPU(NCPU)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .dist_en_i(dist_en_i), .cpu_en_i(cpu_en_i),
    .enable_i(enable_i), .pending_i(pending_i), .prio_bank_i(prio_bank_i),
    .prio_shared_i(prio_shared_i), .pmask_i(pmask_i), .run_prio_i(run_prio_i),
    .hp_id_o(hp_id_o), .irq_o(irq_o)
);

// File: tb/gic_prio_select_tb.sv
`timescale 1ns/1ps
module gic_prio_select_tb;
    localparam int NIRQ = 64;
    localparam int NCPU = 2;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   dist_en = 1'b0;
    logic [NCPU-1:0]        cpu_en = '0;
    logic [NCPU*NIRQ-1:0]   en = '0, pend = '0;
    logic [NCPU*256-1:0]    bank = '0;
    logic [(NIRQ-32)*8-1:0] shared = '0;
    logic [NCPU*8-1:0]      pmask = '0;
    logic [NCPU*9-1:0]      runp = '0;
    logic [NCPU*10-1:0]     hp;
    logic [NCPU-1:0]        irq;

    always #2.5 clk = ~clk;

    gic_prio_select #(.NIRQ(NIRQ), .NCPU(NCPU)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .dist_en_i(dist_en), .cpu_en_i(cpu_en),
        .enable_i(en), .pending_i(pend), .prio_bank_i(bank), .prio_shared_i(shared),
        .pmask_i(pmask), .run_prio_i(runp), .hp_id_o(hp), .irq_o(irq)
    );

    int    checks = 0, failures = 0;
    bit    done = 0;
    string tag = "R1";
    int    exp_hp [NCPU];
    bit    exp_irq[NCPU];

    function automatic int prio(int c, int id);
        if (id < 32) return int'(bank[(c*32+id)*8 +: 8]);
        return int'(shared[(id-32)*8 +: 8]);
    endfunction

    task automatic check(string req, int act, int expv, string what);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic model();
        for (int c = 0; c < NCPU; c++) begin
            int best = 256, bid = 1023;
            for (int id = 0; id < NIRQ; id++)
                if (en[c*NIRQ+id] && pend[c*NIRQ+id] && prio(c, id) < best) begin
                    best = prio(c, id);
                    bid = id;
                end
            exp_hp[c] = 1023; exp_irq[c] = 0;
            if (dist_en && cpu_en[c] && best <= int'(pmask[c*8 +: 8])) begin
                exp_hp[c] = bid;
                exp_irq[c] = best < int'(runp[c*9 +: 9]);
            end
        end
    endtask

    task automatic compare(string req);
        for (int c = 0; c < NCPU; c++) begin
            int h = int'(hp[c*10 +: 10]);
            check(req, h, exp_hp[c], $sformatf("cpu%0d hp_id", c));
            check(req, int'(irq[c]), int'(exp_irq[c]), $sformatf("cpu%0d irq", c));
            check("R9", int'(h == 1023 || h < NIRQ), 1, $sformatf("cpu%0d id range", c));
        end
    endtask

    task automatic step();
        @(posedge clk); model();
        @(negedge clk); compare(tag);
    endtask

    task automatic setp(int c, int id, int v);
        if (id < 32) bank[(c*32+id)*8 +: 8] = 8'(v);
        else shared[(id-32)*8 +: 8] = 8'(v);
    endtask

    task automatic arm(int c, int id);
        en[c*NIRQ+id] = 1'b1; pend[c*NIRQ+id] = 1'b1;
    endtask

    task automatic clear_all();
        en = '0; pend = '0;
    endtask

    initial begin
        for (int c = 0; c < NCPU; c++) begin
            pmask[c*8 +: 8] = 8'hF0;
            runp[c*9 +: 9] = 9'h100;
            for (int id = 0; id < 32; id++) setp(c, id, 8'h80);
        end
        for (int id = 32; id < NIRQ; id++) setp(0, id, 8'h80);
        dist_en = 1; cpu_en = '1; en = '1; pend = '1;
        repeat (3) @(negedge clk);
        tag = "R1";
        for (int c = 0; c < NCPU; c++) begin
            check("R1", int'(hp[c*10 +: 10]), 1023, "reset hp_id");
            check("R1", int'(irq[c]), 0, "reset irq");
        end
        rst_n = 1;

        // R2: distributor off, then one CPU interface off
        tag = "R2"; clear_all(); arm(0, 3); arm(1, 3); dist_en = 0;
        step(); step();
        dist_en = 1; cpu_en = 2'b01; step();
        cpu_en = 2'b10; step();
        cpu_en = '1;

        // R3: enable without pending, pending without enable, crossed CPUs
        tag = "R3"; clear_all();
        en[0*NIRQ+10] = 1; en[1*NIRQ+10] = 1; step();
        clear_all(); pend[0*NIRQ+11] = 1; step();
        clear_all(); en[1*NIRQ+12] = 1; pend[0*NIRQ+12] = 1; step();
        en[0*NIRQ+12] = 1; step();

        // R4: lowest value wins, ties go to the lower ID
        tag = "R4"; clear_all();
        setp(0, 40, 8'h40); setp(0, 50, 8'h40); setp(0, 63, 8'h20);
        arm(0, 5); arm(0, 40); arm(0, 50); arm(0, 63); step();
        en[0*NIRQ+63] = 0; step();
        setp(0, 0, 8'h40); arm(0, 0); step();
        setp(0, 0, 8'h80);

        // R5: banked IDs differ per CPU, shared ID is common
        tag = "R5"; clear_all();
        setp(0, 7, 8'h90); setp(1, 7, 8'h10); setp(0, 33, 8'h50);
        arm(0, 7); arm(1, 7); arm(0, 33); arm(1, 33); step();
        setp(1, 7, 8'h60); step();
        setp(0, 7, 8'h80); setp(1, 7, 8'h80);

        // R6: mask boundary
        tag = "R6"; clear_all(); setp(0, 20, 8'h70); setp(1, 20, 8'hF0); arm(0, 20); arm(1, 20);
        pmask[0 +: 8] = 8'h70; step();
        pmask[0 +: 8] = 8'h6F; step();
        setp(1, 20, 8'hF1); step();
        pmask[0 +: 8] = 8'hF0;

        // R7: running priority boundary
        tag = "R7"; setp(0, 20, 8'h40);
        runp[0 +: 9] = 9'h040; step();
        runp[0 +: 9] = 9'h041; step();
        runp[0 +: 9] = 9'h000; step();
        runp[0 +: 9] = 9'h100; step();

        // R8: an input change is invisible until the next edge
        tag = "R8"; clear_all(); step();
        arm(0, 9); arm(1, 9); #1;
        for (int c = 0; c < NCPU; c++)
            check("R8", int'(hp[c*10 +: 10]), 1023, "hp_id before edge");
        step();

        // R4: random mix
        tag = "R4";
        for (int k = 0; k < 400; k++) begin
            for (int b = 0; b < NCPU*NIRQ; b++) begin
                en[b] = ($urandom % 3) != 0;
                pend[b] = ($urandom % 8) == 0;
            end
            for (int c = 0; c < NCPU; c++) begin
                for (int id = 0; id < 32; id++) setp(c, id, $urandom % 16 * 16);
                pmask[c*8 +: 8] = 8'($urandom);
                runp[c*9 +: 9] = ($urandom % 4 == 0) ? 9'h100 : 9'($urandom % 256);
            end
            for (int id = 32; id < NIRQ; id++) setp(0, id, $urandom % 16 * 16);
            dist_en = ($urandom % 10) != 0;
            cpu_en = 2'($urandom | 32'h1);
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog tag=%s actual=timeout expected=finish", tag);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule